// File: doc/BRIEF.md
# Display Serial Link Read Response Parser

This block sits behind the receive side of a display serial link host. After the host asks a peripheral for data and the link turns around, the peripheral sends back one response packet. The parser takes the packet header and any payload words and turns them into something a host can use: the returned data bytes on a readout port, two progress flags and a final result code.

The host arms the parser with a single `start` pulse. That pulse carries the virtual channel the host expects and the size of its receive buffer in bytes. The parser then decodes the 24-bit header, which holds data type, channel and word count; the ECC byte has already been checked and stripped. There are four outcomes:
- A short read response yields its one or two bytes straight from the word-count field.
- An acknowledge-and-error report ends with a protocol error and exposes the error bits.
- A long response is checked against the buffer size and then unpacked from payload words.
- A channel mismatch ends the transfer with an invalid-argument result.

Once the result is posted, the block goes back to idle and is ready for the next request.

Top module: `dsi_rsp_parser`

## Requirements
- R1: A `start_i` pulse while idle latches `exp_vc_i` and `buf_len_i`, clears both status flags and sets `result_o` to NONE (2'b00). A `start_i` pulse while a transfer is in progress has no effect.
- R2: Header bit layout is data type in bits [5:0], virtual channel in [7:6] and word count in [23:8]. A header is accepted only while the block waits for one, and acceptance sets `hdr_rcvd_o`. In idle, `hdr_valid_i` has no effect.
- R3: A header whose channel differs from the expected channel ends the transfer with result BADARG (2'b10) and delivers no data.
- R4: Two-byte short response (type 0x12 or 0x22): lane 0 carries word count [7:0] when the buffer size exceeds 0, and lane 1 carries word count [15:8] when it exceeds 1. Each lane is marked in `rd_be_o`. The transfer ends OK (2'b01).
- R5: One-byte short response (type 0x11 or 0x21): lane 0 carries word count [7:0] when the buffer size exceeds 0. The transfer ends OK. When no lane is enabled, `rd_valid_o` stays low.
- R6: Generic (0x11/0x12) and DCS (0x21/0x22) short responses decode identically.
- R7: An acknowledge-and-error report (type 0x02) ends the transfer with result PROTO (2'b11), and `err_bits_o` equals its word count.
- R8: Any other type is a long response. If its word count exceeds the buffer size, the transfer ends BADARG without waiting for payload. A count equal to the buffer size is accepted.
- R9: Long payload words pass out one per `pld_valid_i` beat, least significant byte first, with `rd_be_o` all ones. On the final word only the low (count mod 4, or 4) bytes are enabled, and the bytes above them read zero. The transfer then ends OK.
- R10: Payload beats are taken only after an accepted long header. The first one sets `pld_rcvd_o`. Beats in idle or while waiting for the header have no effect.
- R11: `done_o` is a one-cycle pulse issued with the final result. `result_o` and the flags hold until the next accepted `start_i`, and the block is idle in the cycle after `done_o`.
- R12: A long response with word count 0 ends OK immediately, with no readout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Arm the parser for one response |
| exp_vc_i | input | 2 | Expected virtual channel |
| buf_len_i | input | LEN_W | Host buffer size in bytes |
| hdr_valid_i | input | 1 | Header present on `hdr_i` |
| hdr_i | input | 24 | Response header without ECC |
| pld_valid_i | input | 1 | Payload word present on `pld_i` |
| pld_i | input | DATA_W | Payload word, byte 0 in bits [7:0] |
| hdr_rcvd_o | output | 1 | Header accepted this transfer |
| pld_rcvd_o | output | 1 | Payload seen this transfer |
| rd_valid_o | output | 1 | Readout word valid |
| rd_data_o | output | DATA_W | Readout word |
| rd_be_o | output | DATA_W/8 | Byte lanes valid in readout word |
| done_o | output | 1 | Result posted (one cycle) |
| result_o | output | 2 | NONE/OK/BADARG/PROTO |
| err_bits_o | output | 16 | Error bits from an error report |

## Verification
The hardest situations to reach are a second `start_i` arriving mid-payload and payload beats offered before any header is accepted. From the ports alone, both look just like legal traffic. The directed stimulus arms a long response, waits until the block is in its payload phase, and then pulses `start_i` with a different channel and a zero buffer size. If the parser completes the original transfer with the original data, the second pulse was ignored. Likewise, a payload beat sent while waiting for the header must leave `pld_rcvd_o` low and produce no readout.

// File: rtl/dsirp_pkg.sv
package dsirp_pkg;
   localparam int HDR_W = 24;
   localparam int WC_W  = 16;
   localparam int VC_W  = 2;
   localparam int DT_W  = 6;

   typedef enum logic [1:0] {
      K_SHORT1 = 2'd0,
      K_SHORT2 = 2'd1,
      K_ACKERR = 2'd2,
      K_LONG   = 2'd3
   } rsp_kind_e;

   typedef enum logic [1:0] {
      RES_NONE   = 2'b00,
      RES_OK     = 2'b01,
      RES_BADARG = 2'b10,
      RES_PROTO  = 2'b11
   } rsp_res_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HDR  = 2'd1,
      ST_PLD  = 2'd2
   } rsp_st_e;
endpackage

// File: rtl/dsirp_hdr_dec.sv
module dsirp_hdr_dec
   import dsirp_pkg::*;
(
   input  logic [HDR_W-1:0] hdr_i,
   output logic [DT_W-1:0]  dt_o,
   output logic [VC_W-1:0]  vc_o,
   output logic [WC_W-1:0]  wc_o,
   output rsp_kind_e        kind_o
);
   assign dt_o = hdr_i[DT_W-1:0];
   assign vc_o = hdr_i[DT_W+VC_W-1:DT_W];
   assign wc_o = hdr_i[HDR_W-1:DT_W+VC_W];

   // generic and DCS short variants share a decode
   always_comb begin
      unique case (dt_o)
         6'h11, 6'h21: kind_o = K_SHORT1;
         6'h12, 6'h22: kind_o = K_SHORT2;
         6'h02:        kind_o = K_ACKERR;
         default:      kind_o = K_LONG;
      endcase
   end
endmodule

// File: rtl/dsirp_unpack.sv
module dsirp_unpack
   import dsirp_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8
)(
   input  logic [WC_W-1:0]   rem_i,
   input  logic [DATA_W-1:0] word_i,
   output logic [DATA_W-1:0] word_o,
   output logic [BYTES-1:0]  be_o,
   output logic              last_o
);
   localparam logic [WC_W-1:0] STEP = WC_W'(BYTES);

   for (genvar i = 0; i < BYTES; i++) begin : g_lane
      assign be_o[i]           = (rem_i > WC_W'(i));
      assign word_o[8*i +: 8]  = be_o[i] ? word_i[8*i +: 8] : 8'h00;
   end

   assign last_o = (rem_i <= STEP);
endmodule

// File: rtl/dsi_rsp_parser.sv
module dsi_rsp_parser
   import dsirp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16,
   localparam int BYTES = DATA_W / 8
)(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [VC_W-1:0]     exp_vc_i,
   input  logic [LEN_W-1:0]    buf_len_i,
   input  logic                hdr_valid_i,
   input  logic [HDR_W-1:0]    hdr_i,
   input  logic                pld_valid_i,
   input  logic [DATA_W-1:0]   pld_i,
   output logic                hdr_rcvd_o,
   output logic                pld_rcvd_o,
   output logic                rd_valid_o,
   output logic [DATA_W-1:0]   rd_data_o,
   output logic [BYTES-1:0]    rd_be_o,
   output logic                done_o,
   output logic [1:0]          result_o,
   output logic [WC_W-1:0]     err_bits_o
);
   localparam int CMP_W = (LEN_W > WC_W) ? LEN_W : WC_W;
   localparam logic [WC_W-1:0] STEP = WC_W'(BYTES);

   if (DATA_W % 8 != 0) begin : g_bad_width
      $error("DATA_W must be a whole number of bytes");
   end
   if (BYTES < 2) begin : g_bad_lanes
      $error("DATA_W must hold at least two byte lanes");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("LEN_W must be at least 1");
   end

   rsp_st_e           st_q;
   logic [VC_W-1:0]   vc_q;
   logic [LEN_W-1:0]  len_q;
   logic [WC_W-1:0]   rem_q;

   logic [DT_W-1:0]   h_dt;
   logic [VC_W-1:0]   h_vc;
   logic [WC_W-1:0]   h_wc;
   rsp_kind_e         h_kind;

   dsirp_hdr_dec u_dec (
      .hdr_i  (hdr_i),
      .dt_o   (h_dt),
      .vc_o   (h_vc),
      .wc_o   (h_wc),
      .kind_o (h_kind)
   );

   logic [DATA_W-1:0] up_data;
   logic [BYTES-1:0]  up_be;
   logic              up_last;

   dsirp_unpack #(.DATA_W(DATA_W)) u_unp (
      .rem_i  (rem_q),
      .word_i (pld_i),
      .word_o (up_data),
      .be_o   (up_be),
      .last_o (up_last)
   );

   // short response lanes come from the word count field
   logic [BYTES-1:0]  sh_be;
   logic [DATA_W-1:0] sh_data;
   logic              wc_too_big;
   logic              dt_unused;

   always_comb begin
      sh_be    = '0;
      sh_data  = '0;
      sh_be[0] = (len_q != '0);
      sh_be[1] = (h_kind == K_SHORT2) && (len_q > LEN_W'(1));
      if (sh_be[0]) sh_data[7:0]  = h_wc[7:0];
      if (sh_be[1]) sh_data[15:8] = h_wc[15:8];
   end

   assign wc_too_big = CMP_W'(h_wc) > CMP_W'(len_q);
   assign dt_unused  = ^h_dt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         vc_q       <= '0;
         len_q      <= '0;
         rem_q      <= '0;
         hdr_rcvd_o <= 1'b0;
         pld_rcvd_o <= 1'b0;
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
         rd_be_o    <= '0;
         done_o     <= 1'b0;
         result_o   <= RES_NONE;
         err_bits_o <= '0;
      end else begin
         rd_valid_o <= 1'b0;
         done_o     <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  st_q       <= ST_HDR;
                  vc_q       <= exp_vc_i;
                  len_q      <= buf_len_i;
                  hdr_rcvd_o <= 1'b0;
                  pld_rcvd_o <= 1'b0;
                  result_o   <= RES_NONE;
                  err_bits_o <= '0;
               end
            end
            ST_HDR: begin
               if (hdr_valid_i) begin
                  hdr_rcvd_o <= 1'b1;
                  if (h_vc != vc_q) begin
                     st_q     <= ST_IDLE;
                     done_o   <= 1'b1;
                     result_o <= RES_BADARG;
                  end else begin
                     unique case (h_kind)
                        K_SHORT1, K_SHORT2: begin
                           rd_valid_o <= |sh_be;
                           rd_data_o  <= sh_data;
                           rd_be_o    <= sh_be;
                           st_q       <= ST_IDLE;
                           done_o     <= 1'b1;
                           result_o   <= RES_OK;
                        end
                        K_ACKERR: begin
                           err_bits_o <= h_wc;
                           st_q       <= ST_IDLE;
                           done_o     <= 1'b1;
                           result_o   <= RES_PROTO;
                        end
                        default: begin
                           if (wc_too_big) begin
                              st_q     <= ST_IDLE;
                              done_o   <= 1'b1;
                              result_o <= RES_BADARG;
                           end else if (h_wc == '0) begin
                              st_q     <= ST_IDLE;
                              done_o   <= 1'b1;
                              result_o <= RES_OK;
                           end else begin
                              rem_q <= h_wc;
                              st_q  <= ST_PLD;
                           end
                        end
                     endcase
                  end
               end
            end
            ST_PLD: begin
               if (pld_valid_i) begin
                  pld_rcvd_o <= 1'b1;
                  rd_valid_o <= 1'b1;
                  rd_data_o  <= up_data;
                  rd_be_o    <= up_be;
                  if (up_last) begin
                     rem_q    <= '0;
                     st_q     <= ST_IDLE;
                     done_o   <= 1'b1;
                     result_o <= RES_OK;
                  end else begin
                     rem_q <= rem_q - STEP;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // data type bits are consumed only through the kind decode
   logic unused_ok;
   assign unused_ok = dt_unused;
endmodule

// File: rtl/dsi_rsp_parser_chk.sv
module dsi_rsp_parser_chk #(
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8
)(
   input logic              clk,
   input logic              rst_n,
   input logic              hdr_rcvd_o,
   input logic              pld_rcvd_o,
   input logic              rd_valid_o,
   input logic [DATA_W-1:0] rd_data_o,
   input logic [BYTES-1:0]  rd_be_o,
   input logic              done_o,
   input logic [1:0]        result_o
);
   logic [DATA_W-1:0] lane_mask;
   always_comb begin
      for (int i = 0; i < BYTES; i++) lane_mask[8*i +: 8] = {8{rd_be_o[i]}};
   end

   assert_pld_needs_hdr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pld_rcvd_o |-> hdr_rcvd_o);

   assert_rd_after_hdr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> hdr_rcvd_o);

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (result_o != 2'b00));

   assert_be_contig_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> ((rd_be_o & (rd_be_o + BYTES'(1))) == '0));

   assert_mask_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> ((rd_data_o & ~lane_mask) == '0));
endmodule

bind dsi_rsp_parser dsi_rsp_parser_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hdr_rcvd_o (hdr_rcvd_o),
   .pld_rcvd_o (pld_rcvd_o),
   .rd_valid_o (rd_valid_o),
   .rd_data_o  (rd_data_o),
   .rd_be_o    (rd_be_o),
   .done_o     (done_o),
   .result_o   (result_o)
);

// File: tb/dsi_rsp_parser_tb.sv
module dsi_rsp_parser_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W = 32;
   localparam int LEN_W  = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  exp_vc_i = '0;
   logic [15:0] buf_len_i = '0;
   logic        hdr_valid_i = 1'b0;
   logic [23:0] hdr_i = '0;
   logic        pld_valid_i = 1'b0;
   logic [31:0] pld_i = '0;
   logic        hdr_rcvd_o, pld_rcvd_o, rd_valid_o, done_o;
   logic [31:0] rd_data_o;
   logic [3:0]  rd_be_o;
   logic [1:0]  result_o;
   logic [15:0] err_bits_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dsi_rsp_parser #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .exp_vc_i(exp_vc_i),
      .buf_len_i(buf_len_i), .hdr_valid_i(hdr_valid_i), .hdr_i(hdr_i),
      .pld_valid_i(pld_valid_i), .pld_i(pld_i), .hdr_rcvd_o(hdr_rcvd_o),
      .pld_rcvd_o(pld_rcvd_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
      .rd_be_o(rd_be_o), .done_o(done_o), .result_o(result_o),
      .err_bits_o(err_bits_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [23:0] mk_hdr(input logic [5:0] dt, input logic [1:0] vc,
                                          input logic [15:0] wc);
      return {wc, vc, dt};
   endfunction

   // each beat: drive on a falling edge, sample at the next falling edge
   task automatic arm(input logic [1:0] vc, input logic [15:0] len);
      @(negedge clk);
      start_i = 1'b1; exp_vc_i = vc; buf_len_i = len;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic send_hdr(input logic [5:0] dt, input logic [1:0] vc, input logic [15:0] wc);
      hdr_valid_i = 1'b1; hdr_i = mk_hdr(dt, vc, wc);
      @(negedge clk);
      hdr_valid_i = 1'b0;
   endtask

   task automatic send_pld(input logic [31:0] w);
      pld_valid_i = 1'b1; pld_i = w;
      @(negedge clk);
      pld_valid_i = 1'b0;
   endtask

   task automatic t_reset;
      check(result_o == 2'b00, "R1", "reset result", 32'(result_o), 0);
      check(!hdr_rcvd_o && !pld_rcvd_o && !rd_valid_o && !done_o, "R11", "reset flags",
            {28'd0, hdr_rcvd_o, pld_rcvd_o, rd_valid_o, done_o}, 0);
   endtask

   task automatic t_short2;
      arm(2'd1, 16'd4);
      send_hdr(6'h12, 2'd1, 16'hBEEF);
      check(rd_valid_o && rd_data_o == 32'h0000BEEF, "R4", "2B data", rd_data_o, 32'h0000BEEF);
      check(rd_be_o == 4'b0011, "R4", "2B lanes", 32'(rd_be_o), 32'h3);
      check(done_o && result_o == 2'b01 && hdr_rcvd_o, "R2", "2B done ok",
            32'(result_o), 32'h1);
      arm(2'd1, 16'd1);
      send_hdr(6'h22, 2'd1, 16'hBEEF);
      check(rd_valid_o && rd_data_o == 32'h000000EF && rd_be_o == 4'b0001, "R6",
            "DCS 2B len1", rd_data_o, 32'hEF);
   endtask

   task automatic t_short1;
      arm(2'd0, 16'd3);
      send_hdr(6'h21, 2'd0, 16'h12A5);
      check(rd_valid_o && rd_data_o == 32'h000000A5 && rd_be_o == 4'b0001, "R5",
            "1B data", rd_data_o, 32'hA5);
      arm(2'd0, 16'd0);
      send_hdr(6'h11, 2'd0, 16'h12A5);
      check(!rd_valid_o && done_o && result_o == 2'b01, "R5", "1B len0",
            {30'd0, rd_valid_o, done_o}, 32'h1);
   endtask

   task automatic t_vc;
      arm(2'd2, 16'd8);
      send_hdr(6'h12, 2'd3, 16'h0102);
      check(done_o && result_o == 2'b10 && !rd_valid_o, "R3", "vc mismatch",
            32'(result_o), 32'h2);
   endtask

   task automatic t_ackerr;
      arm(2'd0, 16'd8);
      send_hdr(6'h02, 2'd0, 16'h0480);
      check(done_o && result_o == 2'b11, "R7", "ack result", 32'(result_o), 32'h3);
      check(err_bits_o == 16'h0480, "R7", "err bits", 32'(err_bits_o), 32'h0480);
      @(negedge clk);
      check(!done_o && result_o == 2'b11, "R11", "result holds",
            {29'd0, done_o, result_o}, 32'h3);
      arm(2'd0, 16'd8);
      check(result_o == 2'b00 && !hdr_rcvd_o, "R1", "start clears", 32'(result_o), 0);
      send_hdr(6'h11, 2'd0, 16'h0001);
   endtask

   task automatic t_overflow;
      arm(2'd0, 16'd8);
      send_hdr(6'h1A, 2'd0, 16'd9);
      check(done_o && result_o == 2'b10 && !rd_valid_o, "R8", "long too big",
            32'(result_o), 32'h2);
      arm(2'd0, 16'd8);
      send_hdr(6'h1A, 2'd0, 16'd8);
      check(!done_o && hdr_rcvd_o, "R8", "long equal accepted", 32'(done_o), 0);
      send_pld(32'h03020100);
      check(rd_valid_o && rd_be_o == 4'hF && !done_o, "R9", "full word 1",
            32'(rd_be_o), 32'hF);
      send_pld(32'h07060504);
      check(rd_data_o == 32'h07060504 && rd_be_o == 4'hF && done_o && result_o == 2'b01,
            "R9", "exact last word", rd_data_o, 32'h07060504);
   endtask

   task automatic t_long_partial;
      arm(2'd3, 16'd16);
      pld_valid_i = 1'b1; pld_i = 32'hFFFFFFFF;   // beat before header
      @(negedge clk);
      pld_valid_i = 1'b0;
      check(!pld_rcvd_o && !rd_valid_o, "R10", "early payload ignored",
            {30'd0, pld_rcvd_o, rd_valid_o}, 0);
      send_hdr(6'h1C, 2'd3, 16'd7);
      send_pld(32'h44332211);
      check(rd_valid_o && rd_data_o == 32'h44332211 && pld_rcvd_o, "R10", "first word",
            rd_data_o, 32'h44332211);
      send_pld(32'hDDCCBBAA);
      check(rd_data_o == 32'h00CCBBAA && rd_be_o == 4'b0111, "R9", "partial last word",
            rd_data_o, 32'h00CCBBAA);
      check(done_o && result_o == 2'b01, "R9", "partial done", 32'(result_o), 32'h1);
   endtask

   task automatic t_busy_start;
      arm(2'd1, 16'd8);
      send_hdr(6'h1A, 2'd1, 16'd5);
      arm(2'd2, 16'd0);                            // must be ignored
      send_pld(32'hA3A2A1A0);
      check(rd_data_o == 32'hA3A2A1A0 && !done_o, "R1", "busy start ignored",
            rd_data_o, 32'hA3A2A1A0);
      send_pld(32'hB3B2B1B0);
      check(rd_data_o == 32'h000000B0 && rd_be_o == 4'b0001 && done_o && result_o == 2'b01,
            "R1", "transfer kept", rd_data_o, 32'hB0);
   endtask

   task automatic t_idle_ignore;
      @(negedge clk);
      hdr_valid_i = 1'b1; hdr_i = mk_hdr(6'h11, 2'd0, 16'h0055);
      pld_valid_i = 1'b1; pld_i = 32'h12345678;
      @(negedge clk);
      hdr_valid_i = 1'b0; pld_valid_i = 1'b0;
      check(!rd_valid_o && !done_o && result_o == 2'b01, "R2", "idle header ignored",
            {29'd0, rd_valid_o, done_o, result_o[0]}, 32'h1);
   endtask

   task automatic t_zero;
      arm(2'd0, 16'd4);
      send_hdr(6'h1A, 2'd0, 16'd0);
      check(done_o && result_o == 2'b01 && !rd_valid_o, "R12", "zero length long",
            32'(result_o), 32'h1);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_short2();
      t_short1();
      t_vc();
      t_ackerr();
      t_overflow();
      t_long_partial();
      t_busy_start();
      t_idle_ignore();
      t_zero();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule